// File: doc/BRIEF.md
# NAND Flash Single-Page Read Sequencer

This block walks an 8-bit NAND flash device through a complete page fetch and returns the 512 bytes as a stream. The host pulses `start_i` with a 33-bit flash address. On the first request after reset, the sequencer first sends the device reset command 0xFF and waits for the device to report ready. It then sends the read command 0x00 and four address bytes, and waits for ready again. Finally it toggles the read strobe 512 times. Each byte read appears on `rd_data_o` with a one-cycle `rd_valid_o`. A one-cycle `done_o` closes the operation.

The write strobe has three phases: setup, low and hold. Each phase length is set by the host, so one netlist can serve devices with different bus timing. The read strobe uses the same low and hold lengths. The address bytes come from bits 7:0, 16:9, 24:17 and 32:25 of the request address. Bit 8 is never sent, because the page command already selects which half of the page to read.

The control is a single state machine with these states:
- IDLE: waits for `start_i`, then goes to SETUP.
- SETUP, WLOW, WHOLD: these three states form one write cycle.
- After WHOLD, the machine goes to WAITRDY if it has just sent the reset command or the last address byte. Otherwise it goes back to SETUP for the next byte.
- WAITRDY: once the busy line reads 1, it goes to SETUP (after the reset command) or to RLOW (after the address bytes).
- RLOW and RHOLD: these states form one read cycle. After RHOLD the machine returns to RLOW, or goes to DONE after the last byte.
- DONE: lasts one cycle, then returns to IDLE.

Top module: `nand_page_reader`

## Requirements
- R1: While reset is held and in IDLE afterwards, `nce_o`, `nwe_o` and `nre_o` are 1, while `cle_o`, `ale_o`, `io_oe_o`, `done_o` and `rd_valid_o` are 0.
- R2: The first accepted start after reset begins with one write cycle of byte 0xFF with `cle_o`=1. No further strobe occurs until `rnb_i` reads 1.
- R3: Every operation issues one write cycle of byte 0x00 with `cle_o`=1 and `ale_o`=0. Operations after the first do not repeat the reset command.
- R4: After the read command come exactly four write cycles with `ale_o`=1 and `cle_o`=0. They carry addr[7:0], addr[16:9], addr[24:17] and addr[32:25], in that order.
- R5: Three phase lengths apply, each counted in clocks. `nce_o` is low for setup+1 clocks before the first `nwe_o` fall of an operation. `nwe_o` stays low for strobe+1 clocks. Two back-to-back write cycles are separated by hold+setup+2 high clocks. `cle_o`, `ale_o` and `io_o` do not change at the `nwe_o` rising edge.
- R6: After the last address byte, the first `nre_o` fall waits until `rnb_i` reads 1. No strobe falls while `rnb_i` is 0.
- R7: Exactly 512 read cycles follow. In each one, `nre_o` is low for strobe+1 clocks and high for hold+1 clocks between pulses. `io_i` is captured at the `nre_o` rising edge and shown on `rd_data_o` with `rd_valid_o` high for one cycle.
- R8: `nce_o` is 0 from the first setup clock through the last read hold clock, and 1 again in the `done_o` cycle.
- R9: `done_o` is a one-cycle pulse that comes after the 512th byte.
- R10: A start request while an operation runs, including in the `done_o` cycle, is ignored: no new strobes and `nce_o` stays 1 afterwards.
- R11: `cle_o` and `ale_o` are never high together, and `io_oe_o` is 1 at every `nwe_o` rise and 0 whenever `nre_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken only in IDLE |
| addr_i | input | 33 | Flash byte address of the page |
| setup_len_i | input | 4 | Setup phase length minus one |
| strobe_len_i | input | 4 | Strobe-low length minus one |
| hold_len_i | input | 4 | Hold phase length minus one |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Byte read from the page |
| rd_valid_o | output | 1 | `rd_data_o` valid this cycle |
| nce_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| nwe_o | output | 1 | Write strobe, active low |
| nre_o | output | 1 | Read strobe, active low |
| io_o | output | 8 | Byte driven onto the flash bus |
| io_oe_o | output | 1 | Output enable for `io_o` |
| io_i | input | 8 | Byte returned by the flash bus |
| rnb_i | input | 1 | Ready (1) or busy (0) from the device |

## Verification
The closing `done_o` cycle of one operation and the acceptance of a new request can coincide, because the host may retry in the very cycle completion is flagged. The bench raises `start_i` exactly in the `done_o` cycle of the last operation, and also once in the middle of a page read. It then watches the flash pins for a further stretch. Any new write strobe, or `nce_o` dropping again, counts as a failure. The bench also checks that the read-command-only sequence of each later operation and the page contents remain intact.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WLOW,
        ST_WHOLD,
        ST_WAITRDY,
        ST_RLOW,
        ST_RHOLD,
        ST_DONE
    } nrd_state_e;

    // Which byte the current write cycle carries
    typedef enum logic [2:0] {
        IT_RST,
        IT_RDCMD,
        IT_A0,
        IT_A1,
        IT_A2,
        IT_A3
    } nrd_item_e;

    localparam logic [7:0] OP_RESET   = 8'hFF;
    localparam logic [7:0] OP_READ    = 8'h00;
    localparam int         ADDR_BYTES = 4;

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Loaded on phase entry with length-1; the phase ends on the clock it reads zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/nand_addr_slicer.sv
module nand_addr_slicer #(
    parameter int ADDR_W = 33,
    parameter int NBYTES = 4,
    localparam int SEL_W = $clog2(NBYTES)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [7:0]        byte_o
);
    logic [7:0] slice [NBYTES];
    logic       col_bit_unused;

    // Byte 0 is the column; later bytes skip bit 8 (half-page select is in the command)
    for (genvar k = 0; k < NBYTES; k++) begin : g_slice
        localparam int LO = (k == 0) ? 0 : 8 * k + 1;
        assign slice[k] = addr_i[LO+7:LO];
    end

    assign col_bit_unused = addr_i[8];
    assign byte_o = slice[sel_i];
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
    import nand_rd_pkg::*;
#(
    parameter int ADDR_W     = 33,
    parameter int CNT_W      = 4,
    parameter int PAGE_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  setup_len_i,
    input  logic [CNT_W-1:0]  strobe_len_i,
    input  logic [CNT_W-1:0]  hold_len_i,
    output logic              done_o,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o,
    output logic              nce_o,
    output logic              cle_o,
    output logic              ale_o,
    output logic              nwe_o,
    output logic              nre_o,
    output logic [7:0]        io_o,
    output logic              io_oe_o,
    input  logic [7:0]        io_i,
    input  logic              rnb_i
);
    localparam int BC_W = $clog2(PAGE_BYTES + 1);
    localparam int AS_W = $clog2(ADDR_BYTES);

    nrd_state_e        state_q, state_n;
    nrd_item_e         item_q;
    logic              init_done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BC_W-1:0]   bcnt_q;
    logic              ph_load, ph_end;
    logic [CNT_W-1:0]  ph_len;
    logic [AS_W-1:0]   adr_sel;
    logic [7:0]        adr_byte;
    logic              write_ph;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    nand_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ph_load),
        .len_i     (ph_len),
        .expired_o (ph_end)
    );

    assign adr_sel = AS_W'(item_q - IT_A0);

    nand_addr_slicer #(.ADDR_W(ADDR_W), .NBYTES(ADDR_BYTES)) u_slicer (
        .addr_i (addr_q),
        .sel_i  (adr_sel),
        .byte_o (adr_byte)
    );

    // Next-state decision
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_n = ST_SETUP;
            ST_SETUP:   if (ph_end) state_n = ST_WLOW;
            ST_WLOW:    if (ph_end) state_n = ST_WHOLD;
            ST_WHOLD:   if (ph_end)
                            state_n = (item_q == IT_RST || item_q == IT_A3) ? ST_WAITRDY : ST_SETUP;
            ST_WAITRDY: if (rnb_i)
                            state_n = (item_q == IT_RST) ? ST_SETUP : ST_RLOW;
            ST_RLOW:    if (ph_end) state_n = ST_RHOLD;
            ST_RHOLD:   if (ph_end)
                            state_n = (bcnt_q == BC_W'(PAGE_BYTES)) ? ST_DONE : ST_RLOW;
            ST_DONE:    state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // Phase length chosen for the state being entered
    always_comb begin
        ph_load = (state_n != state_q);
        unique case (state_n)
            ST_SETUP:          ph_len = setup_len_i;
            ST_WLOW, ST_RLOW:  ph_len = strobe_len_i;
            ST_WHOLD, ST_RHOLD: ph_len = hold_len_i;
            default:           ph_len = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    // Sequence bookkeeping: which byte, first-use flag, captured address, byte count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            item_q      <= IT_RST;
            init_done_q <= 1'b0;
            addr_q      <= '0;
            bcnt_q      <= '0;
        end else begin
            if (accept) begin
                item_q <= init_done_q ? IT_RDCMD : IT_RST;
                addr_q <= addr_i;
                bcnt_q <= '0;
            end else if (state_q == ST_WHOLD && ph_end &&
                         item_q != IT_RST && item_q != IT_A3) begin
                item_q <= nrd_item_e'(item_q + 3'd1);
            end else if (state_q == ST_WAITRDY && rnb_i && item_q == IT_RST) begin
                item_q      <= IT_RDCMD;
                init_done_q <= 1'b1;
            end
            if (state_q == ST_RLOW && ph_end)
                bcnt_q <= bcnt_q + 1'b1;
        end
    end

    // Read capture at the read-strobe rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= (state_q == ST_RLOW) && ph_end;
            if ((state_q == ST_RLOW) && ph_end)
                rd_data_o <= io_i;
        end
    end

    // Pin outputs
    always_comb begin
        write_ph = (state_q == ST_SETUP) || (state_q == ST_WLOW) || (state_q == ST_WHOLD);
        nce_o    = (state_q == ST_IDLE) || (state_q == ST_DONE);
        nwe_o    = (state_q != ST_WLOW);
        nre_o    = (state_q != ST_RLOW);
        cle_o    = write_ph && (item_q == IT_RST || item_q == IT_RDCMD);
        ale_o    = write_ph && !(item_q == IT_RST || item_q == IT_RDCMD);
        io_oe_o  = write_ph;
        done_o   = (state_q == ST_DONE);
        unique case (item_q)
            IT_RST:   io_o = OP_RESET;
            IT_RDCMD: io_o = OP_READ;
            default:  io_o = adr_byte;
        endcase
        if (!write_ph)
            io_o = 8'h00;
    end
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cle_o,
    input logic       ale_o,
    input logic       nce_o,
    input logic       nwe_o,
    input logic       nre_o,
    input logic [7:0] io_o,
    input logic       io_oe_o,
    input logic       rnb_i,
    input logic       done_o,
    input logic       rd_valid_o
);
    a_r11_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));

    a_r8_strobe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!nwe_o || !nre_o) |-> !nce_o);

    a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !nre_o |-> !io_oe_o);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> nce_o);

    a_r5_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nwe_o) |-> ($stable(cle_o) && $stable(ale_o) && $stable(io_o)));

    a_r6_read_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nre_o) |-> $past(rnb_i));

    a_r7_valid_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $rose(nre_o));
endmodule

bind nand_page_reader nand_page_reader_chk u_chk (.*);

// File: tb/nand_page_reader_tb.sv
module nand_page_reader_tb;
    localparam int PAGE = 512;
    localparam int CW   = 4;
    localparam int AW   = 33;
    localparam int BUSY_CLKS = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] setup_len = '0, strobe_len = '0, hold_len = '0;
    logic          done_o, rd_valid_o, nce_o, cle_o, ale_o, nwe_o, nre_o, io_oe_o;
    logic [7:0]    rd_data_o, io_o;
    logic [7:0]    io_i = 8'h00;
    logic          rnb_i = 1'b1;

    always #2 clk = ~clk;

    nand_page_reader u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .setup_len_i(setup_len), .strobe_len_i(strobe_len), .hold_len_i(hold_len),
        .done_o(done_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
        .nce_o(nce_o), .cle_o(cle_o), .ale_o(ale_o), .nwe_o(nwe_o), .nre_o(nre_o),
        .io_o(io_o), .io_oe_o(io_oe_o), .io_i(io_i), .rnb_i(rnb_i)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] s, input int i);
        return 8'(s + 8'(i * 5) + 8'(i >> 8));
    endfunction

    logic [9:0] exp_wr[$];
    logic [7:0] exp_rd[$];
    int rd_seen = 0;
    int strobes = 0;
    logic [7:0] seed = 8'h00;
    int midx = 0;
    int acnt = 0;
    int rb_acnt = 0;

    // Scoreboard monitor for write cycles plus flash model bookkeeping
    always @(posedge nwe_o) begin
        logic [9:0] got, e;
        got = {cle_o, ale_o, io_o};
        strobes++;
        if (exp_wr.size() == 0) chk(1'b0, "R10 unexpected write strobe", got, 0);
        else begin
            e = exp_wr.pop_front();
            chk(got == e, "R4 command/address cycle (R2 R3)", got, e);
        end
        chk(io_oe_o == 1'b1, "R11 bus driven at strobe", io_oe_o, 1);
        if (cle_o) begin
            acnt = 0;
            if (io_o == 8'h00) midx = 0;
        end else if (ale_o) begin
            if (acnt == 0) seed = io_o;
            acnt++;
        end
    end

    // Ready/busy model
    always @(posedge nwe_o) begin
        if (cle_o) rb_acnt = 0;
        else if (ale_o) rb_acnt++;
        if ((cle_o && io_o == 8'hFF) || (ale_o && rb_acnt == 4)) begin
            rnb_i = 1'b0;
            repeat (BUSY_CLKS) @(negedge clk);
            rnb_i = 1'b1;
        end
    end

    // Data model: next byte presented when read strobe falls
    always @(negedge nre_o) begin
        io_i = pat(seed, midx);
        midx++;
    end

    // Scoreboard monitor for read bytes
    always @(negedge clk) begin
        logic [7:0] e;
        if (rst_n && rd_valid_o) begin
            if (exp_rd.size() == 0) chk(1'b0, "R7 extra byte", rd_data_o, 0);
            else begin
                e = exp_rd.pop_front();
                chk(rd_data_o == e, "R7 page byte", rd_data_o, e);
            end
            rd_seen++;
        end
    end

    // Timing monitor
    logic nwe_p = 1'b1, nre_p = 1'b1;
    int wlo = 0, whi = 0, rlo = 0, rhi = 0, ce_run = 0;
    bit first_w = 1'b1, nre_any = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nwe_o && nwe_p) begin
                if (first_w)
                    chk(ce_run == int'(setup_len) + 1, "R5 setup before first strobe", ce_run, int'(setup_len) + 1);
                else if (ale_o)
                    chk(whi == int'(setup_len) + int'(hold_len) + 2, "R5 gap between write strobes",
                        whi, int'(setup_len) + int'(hold_len) + 2);
                chk(rnb_i, "R6 write strobe while busy", rnb_i, 1);
                first_w = 1'b0;
                nre_any = 1'b0;
                wlo = 0;
            end
            if (nwe_o && !nwe_p) begin
                chk(wlo == int'(strobe_len) + 1, "R5 write strobe width", wlo, int'(strobe_len) + 1);
                whi = 0;
            end
            if (!nre_o && nre_p) begin
                if (nre_any)
                    chk(rhi == int'(hold_len) + 1, "R7 read strobe gap", rhi, int'(hold_len) + 1);
                chk(rnb_i, "R6 read strobe while busy", rnb_i, 1);
                nre_any = 1'b1;
                rlo = 0;
            end
            if (nre_o && !nre_p) begin
                chk(rlo == int'(strobe_len) + 1, "R7 read strobe width", rlo, int'(strobe_len) + 1);
                rhi = 0;
            end
            if (!nwe_o) wlo++; else whi++;
            if (!nre_o) rlo++; else rhi++;
            if (!nce_o) ce_run++;
            else begin
                ce_run = 0;
                first_w = 1'b1;
                nre_any = 1'b0;
            end
            nwe_p = nwe_o;
            nre_p = nre_o;
        end
    end

    bit inited = 1'b0;

    task automatic run_op(input logic [AW-1:0] a, input int su, input int st, input int ho,
                          input bit poke_mid, input bit poke_done);
        int s0;
        setup_len  = CW'(su);
        strobe_len = CW'(st);
        hold_len   = CW'(ho);
        if (!inited) exp_wr.push_back({2'b10, 8'hFF});
        exp_wr.push_back({2'b10, 8'h00});
        exp_wr.push_back({2'b01, a[7:0]});
        exp_wr.push_back({2'b01, a[16:9]});
        exp_wr.push_back({2'b01, a[24:17]});
        exp_wr.push_back({2'b01, a[32:25]});
        for (int i = 0; i < PAGE; i++) exp_rd.push_back(pat(a[7:0], i));
        rd_seen = 0;
        @(negedge clk);
        addr_i  = a;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(nce_o == 1'b0, "R8 chip enable during operation", nce_o, 0);
        if (poke_mid) begin
            repeat (300) @(negedge clk);
            addr_i  = ~a;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk(exp_rd.size() == 0, "R9 done after last byte", exp_rd.size(), 0);
        chk(rd_seen == PAGE, "R7 byte count", rd_seen, PAGE);
        chk(exp_wr.size() == 0, "R4 all address cycles issued", exp_wr.size(), 0);
        chk(nce_o == 1'b1, "R8 released in done cycle", nce_o, 1);
        if (poke_done) begin
            addr_i  = a ^ 33'h1;
            start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R9 done lasts one cycle", done_o, 0);
        inited = 1'b1;
        s0 = strobes;
        repeat (60) @(negedge clk);
        chk(strobes == s0, "R10 no strobes after ignored start", strobes, s0);
        chk(nce_o == 1'b1, "R10 chip stays deselected", nce_o, 1);
        chk(rd_seen == PAGE, "R10 no extra bytes", rd_seen, PAGE);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(nce_o == 1'b1 && nwe_o == 1'b1 && nre_o == 1'b1, "R1 strobes idle in reset",
            {nce_o, nwe_o, nre_o}, 3'b111);
        chk(cle_o == 1'b0 && ale_o == 1'b0 && io_oe_o == 1'b0, "R1 latches idle in reset",
            {cle_o, ale_o, io_oe_o}, 0);
        chk(done_o == 1'b0 && rd_valid_o == 1'b0, "R1 host outputs idle in reset",
            {done_o, rd_valid_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(nce_o == 1'b1 && nwe_o == 1'b1 && nre_o == 1'b1, "R1 idle after reset",
            {nce_o, nwe_o, nre_o}, 3'b111);
        run_op(33'h1_A5C3_3E7F, 1, 2, 0, 1'b0, 1'b0);
        run_op(33'h0_0F0F_1234, 0, 0, 0, 1'b1, 1'b0);
        run_op(33'h1_FFFF_FE01, 3, 1, 2, 1'b0, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule